// File: doc/BRIEF.md
# Ethernet Frame Transmit Formatter

This block turns a raw frame payload into a complete Ethernet frame on a byte-wide output stream. A one-cycle start pulse, taken only while the block is idle, latches the requested payload length, a pad enable, a CRC enable and a pad byte value. The block first sends a fixed preamble of alternating bits and the start-of-frame delimiter. It then forwards the payload from a valid/ready input stream. It adds pad bytes when a short frame must reach the minimum size, and ends with the 32-bit frame check sequence when CRC append is on.

Both streams carry full valid/ready handshakes, so the upstream may leave gaps and the downstream may stall at any byte. The frame content does not change when this happens. The frame ends when the downstream accepts the last byte, which the block marks with a last flag. The next cycle, a done pulse comes out together with a status word: bit 0 is oversize, bit 1 is padded and bit 2 is CRC appended. The busy output falls in the same cycle.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy_o, m_valid_o, done_o and s_ready_o are all low.
- R2: Every frame opens with six bytes of 0x55 followed by one byte of 0xD5.
- R3: After the delimiter, the payload bytes come out in arrival order, and exactly min(len_i, 1514) bytes are taken from the input stream.
- R4: With pad_en_i set and fewer than 60 payload bytes, bytes of the pad_byte_i value latched at start follow the payload until payload plus pad equals 60, and status bit 1 is set. Otherwise no pad byte is sent and bit 1 is clear.
- R5: With crc_en_i set, four check bytes follow the payload and pad, and status bit 2 is set. These bytes are the complement of a reflected CRC-32 (polynomial 0xEDB88320, preset to all ones) computed over payload and pad only, sent least significant byte first. With crc_en_i clear, no check bytes are sent.
- R6: A len_i above 1514 truncates the payload at 1514 bytes, so the frame stops at 1518 bytes after the delimiter, and status bit 0 is set.
- R7: A start pulse while busy_o is high is ignored: the frame in progress is unchanged and no second frame follows.
- R8: m_last_o marks only the final byte of the frame. done_o is a one-cycle pulse in the cycle after that byte is accepted, busy_o is low in that same cycle, and status_o then holds the frame's status.
- R9: A byte offered on the output stays stable until it is accepted. Input gaps and output stalls do not change the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request pulse, taken only while idle |
| len_i | input | 11 | Requested payload length in bytes |
| pad_en_i | input | 1 | Pad short frames to the minimum size |
| crc_en_i | input | 1 | Append the 32-bit check sequence |
| pad_byte_i | input | 8 | Value used for pad bytes |
| s_valid_i | input | 1 | Payload byte valid |
| s_data_i | input | 8 | Payload byte |
| s_ready_o | output | 1 | Payload byte taken this cycle |
| m_valid_o | output | 1 | Frame byte valid |
| m_data_o | output | 8 | Frame byte |
| m_last_o | output | 1 | Final byte of the frame |
| m_ready_i | input | 1 | Downstream accepts the frame byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| status_o | output | 3 | Bit 0 oversize, bit 1 padded, bit 2 CRC appended |

## Verification
A corrupted phase or byte counter would show at the ports almost at once. It gives a wrong preamble length, a misplaced delimiter or a wrong number of payload bytes taken, and the first output byte past the fault is wrong. A fault in the CRC register cannot be seen until the last four bytes, so the check sequence is compared against a bench model and against the well-known value for the ASCII string 123456789. Errors in padding or truncation bounds show up at the boundary lengths 59, 60, 1514 and 1515, in the frame length, in the count of bytes consumed and in the status bits reported with the done pulse.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_PAY,
    PH_PAD,
    PH_FCS,
    PH_DRAIN
  } phase_e;

  localparam int ST_W        = 3;
  localparam int ST_OVERSIZE = 0;
  localparam int ST_PADDED   = 1;
  localparam int ST_CRC      = 2;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320,
  parameter int          DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_i,
  input  logic          upd_i,
  input  logic [DW-1:0] data_i,
  output logic [31:0]   crc_o
);

  logic [31:0]          crc_q;
  logic [DW:0][31:0]    chain;

  assign chain[0] = crc_q;

  // one reflected shift stage per data bit, lsb first
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign chain[g+1] = {1'b0, chain[g][31:1]} ^
                        (POLY & {32{chain[g][0] ^ data_i[g]}});
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) crc_q <= '1;
    else if (upd_i)    crc_q <= chain[DW];
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/eth_tx_outreg.sv
module eth_tx_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_last_i,
  input  logic          ready_i,
  output logic          adv_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);

  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          last_q;

  assign adv_o = !valid_q || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (adv_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        data_q <= in_data_i;
        last_q <= in_last_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int PRE_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pad_en_i,
  input  logic             crc_en_i,
  input  logic [7:0]       pad_byte_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             adv_i,
  input  logic             out_taken_i,
  input  logic [31:0]      crc_i,
  output logic             s_ready_o,
  output logic             gen_valid_o,
  output logic [7:0]       gen_data_o,
  output logic             gen_last_o,
  output logic             crc_init_o,
  output logic             crc_upd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ST_W-1:0]  status_o
);

  localparam int FCS_BYTES = 4;
  localparam int MIN_DATA  = MIN_FRAME - FCS_BYTES;
  localparam int MAX_DATA  = MAX_FRAME - FCS_BYTES;
  localparam int CNT_W     = $clog2(PRE_BYTES + 2);
  localparam logic [LEN_W-1:0] MIN_DATA_L = LEN_W'(MIN_DATA);
  localparam logic [LEN_W-1:0] MAX_DATA_L = LEN_W'(MAX_DATA);
  localparam logic [CNT_W-1:0] SFD_POS    = CNT_W'(PRE_BYTES);
  localparam logic [CNT_W-1:0] FCS_LAST   = CNT_W'(FCS_BYTES - 1);

  phase_e           ph_q, follow;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] dcnt_q, eff_q;
  logic             pad_en_q, crc_en_q, over_q, padded_q, done_q;
  logic [7:0]       pad_q;
  logic [ST_W-1:0]  status_q;
  logic             seg_end, need_pad, fire;
  logic [31:0]      crc_fin;
  logic [4:0]       fcs_sel;

  assign need_pad = pad_en_q && (eff_q < MIN_DATA_L);
  assign crc_fin  = ~crc_i;
  assign fcs_sel  = {cnt_q[1:0], 3'b000};

  // byte generation for the current phase
  always_comb begin
    gen_valid_o = 1'b0;
    gen_data_o  = '0;
    seg_end     = 1'b0;
    unique case (ph_q)
      PH_PRE: begin
        gen_valid_o = 1'b1;
        gen_data_o  = (cnt_q == SFD_POS) ? SFD_BYTE : PRE_BYTE;
        seg_end     = (cnt_q == SFD_POS);
      end
      PH_PAY: begin
        gen_valid_o = s_valid_i;
        gen_data_o  = s_data_i;
        seg_end     = (dcnt_q == eff_q - 1'b1);
      end
      PH_PAD: begin
        gen_valid_o = 1'b1;
        gen_data_o  = pad_q;
        seg_end     = (dcnt_q == MIN_DATA_L - 1'b1);
      end
      PH_FCS: begin
        gen_valid_o = 1'b1;
        gen_data_o  = crc_fin[fcs_sel +: 8];
        seg_end     = (cnt_q == FCS_LAST);
      end
      default: ;
    endcase
  end

  // phase that follows the current one once its last byte leaves
  always_comb begin
    unique case (ph_q)
      PH_PRE:  follow = (eff_q != '0) ? PH_PAY :
                        need_pad ? PH_PAD : crc_en_q ? PH_FCS : PH_DRAIN;
      PH_PAY:  follow = need_pad ? PH_PAD : crc_en_q ? PH_FCS : PH_DRAIN;
      PH_PAD:  follow = crc_en_q ? PH_FCS : PH_DRAIN;
      default: follow = PH_DRAIN;
    endcase
  end

  assign fire        = adv_i && gen_valid_o;
  assign gen_last_o  = gen_valid_o && seg_end && (follow == PH_DRAIN);
  assign s_ready_o   = (ph_q == PH_PAY) && adv_i;
  assign crc_init_o  = (ph_q == PH_IDLE) && start_i;
  assign crc_upd_o   = fire && ((ph_q == PH_PAY) || (ph_q == PH_PAD));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      dcnt_q   <= '0;
      eff_q    <= '0;
      pad_en_q <= 1'b0;
      crc_en_q <= 1'b0;
      over_q   <= 1'b0;
      padded_q <= 1'b0;
      pad_q    <= '0;
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q     <= PH_PRE;
            cnt_q    <= '0;
            dcnt_q   <= '0;
            over_q   <= (len_i > MAX_DATA_L);
            eff_q    <= (len_i > MAX_DATA_L) ? MAX_DATA_L : len_i;
            pad_en_q <= pad_en_i;
            crc_en_q <= crc_en_i;
            pad_q    <= pad_byte_i;
            padded_q <= 1'b0;
          end
        end
        PH_DRAIN: begin
          if (out_taken_i) begin
            ph_q                  <= PH_IDLE;
            done_q                <= 1'b1;
            status_q[ST_OVERSIZE] <= over_q;
            status_q[ST_PADDED]   <= padded_q;
            status_q[ST_CRC]      <= crc_en_q;
          end
        end
        default: begin
          if (fire) begin
            if ((ph_q == PH_PAY) || (ph_q == PH_PAD)) dcnt_q <= dcnt_q + 1'b1;
            if (seg_end) begin
              ph_q  <= follow;
              cnt_q <= '0;
              if (follow == PH_PAD) padded_q <= 1'b1;
            end else if ((ph_q == PH_PRE) || (ph_q == PH_FCS)) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign done_o   = done_q;
  assign status_o = status_q;

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int PRE_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pad_en_i,
  input  logic             crc_en_i,
  input  logic [7:0]       pad_byte_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             m_last_o,
  input  logic             m_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ST_W-1:0]  status_o
);

  logic        adv, gen_valid, gen_last, crc_init, crc_upd, out_taken;
  logic [7:0]  gen_data;
  logic [31:0] crc;

  assign out_taken = m_valid_o && m_ready_i;

  eth_tx_seq #(
    .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
    .MAX_FRAME(MAX_FRAME), .PRE_BYTES(PRE_BYTES)
  ) seq_i (
    .clk(clk), .rst(rst),
    .start_i(start_i), .len_i(len_i),
    .pad_en_i(pad_en_i), .crc_en_i(crc_en_i), .pad_byte_i(pad_byte_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .adv_i(adv), .out_taken_i(out_taken), .crc_i(crc),
    .s_ready_o(s_ready_o),
    .gen_valid_o(gen_valid), .gen_data_o(gen_data), .gen_last_o(gen_last),
    .crc_init_o(crc_init), .crc_upd_o(crc_upd),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  eth_tx_crc32 #(.POLY(CRC_POLY), .DW(8)) crc_i (
    .clk(clk), .rst(rst),
    .init_i(crc_init), .upd_i(crc_upd), .data_i(gen_data),
    .crc_o(crc)
  );

  eth_tx_outreg #(.DW(8)) out_i (
    .clk(clk), .rst(rst),
    .in_valid_i(gen_valid), .in_data_i(gen_data), .in_last_i(gen_last),
    .ready_i(m_ready_i),
    .adv_o(adv), .valid_o(m_valid_o), .data_o(m_data_o), .last_o(m_last_o)
  );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       s_ready_o,
  input logic       m_valid_o,
  input logic [7:0] m_data_o,
  input logic       m_last_o,
  input logic       m_ready_i,
  input logic       busy_o,
  input logic       done_o
);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && m_ready_i && m_last_o) |=> done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  start_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R3
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> busy_o);

endmodule

bind eth_tx_framer eth_tx_framer_chk chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .s_ready_o(s_ready_o),
  .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_last_o(m_last_o),
  .m_ready_i(m_ready_i), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;
  // fields: len[29:19] pad_en[18] crc_en[17] pad_byte[16:9] gap[8] restart_cycle[7:0]
  localparam logic [29:0] VECS [NVEC] = '{
    {11'd64,   1'b1, 1'b1, 8'h88, 1'b0, 8'd0},
    {11'd10,   1'b1, 1'b1, 8'h88, 1'b1, 8'd0},
    {11'd10,   1'b0, 1'b1, 8'h88, 1'b0, 8'd20},
    {11'd59,   1'b1, 1'b0, 8'hA5, 1'b1, 8'd0},
    {11'd60,   1'b1, 1'b1, 8'h88, 1'b0, 8'd0},
    {11'd0,    1'b1, 1'b1, 8'h88, 1'b1, 8'd0},
    {11'd0,    1'b0, 1'b0, 8'h88, 1'b0, 8'd3},
    {11'd1514, 1'b1, 1'b1, 8'h88, 1'b0, 8'd0},
    {11'd1515, 1'b1, 1'b1, 8'h88, 1'b0, 8'd0},
    {11'd2000, 1'b0, 1'b0, 8'h88, 1'b1, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [10:0] len_i = '0;
  logic        pad_en_i = 1'b0, crc_en_i = 1'b0;
  logic [7:0]  pad_byte_i = '0;
  logic        s_valid_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic        m_ready_i = 1'b0;
  logic        s_ready_o, m_valid_o, m_last_o, busy_o, done_o;
  logic [7:0]  m_data_o;
  logic [2:0]  status_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] src_mem [0:2047];
  logic [7:0] exp_b   [0:2047];
  logic [7:0] got_b   [0:2047];
  int         got_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_framer dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .pad_en_i(pad_en_i), .crc_en_i(crc_en_i), .pad_byte_i(pad_byte_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_last_o(m_last_o),
    .m_ready_i(m_ready_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_frame(input int len, input bit pe, input bit ce,
                           input logic [7:0] pb, input bit gap, input int restart);
    int eff, n_exp, data_end, src_idx, dones, post, last_pos, n_last, bad_idx;
    bit padded, done_busy_bad;
    logic [2:0] exp_st, got_st;
    logic [31:0] c;
    string rq;
    eff = (len > 1514) ? 1514 : len;
    n_exp = 0;
    for (int i = 0; i < 6; i++) begin exp_b[n_exp] = 8'h55; n_exp++; end
    exp_b[n_exp] = 8'hD5; n_exp++;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < eff; i++) begin
      exp_b[n_exp] = src_mem[i]; n_exp++;
      c = crc_step(c, src_mem[i]);
    end
    padded = 1'b0;
    if (pe && eff < 60) begin
      padded = 1'b1;
      while (n_exp < 67) begin
        exp_b[n_exp] = pb; n_exp++;
        c = crc_step(c, pb);
      end
    end
    data_end = n_exp;
    if (ce) for (int k = 0; k < 4; k++) begin
      exp_b[n_exp] = ~c[8*k +: 8]; n_exp++;
    end
    exp_st = {ce, padded, (len > 1514)};

    @(negedge clk);
    start_i = 1'b1; len_i = 11'(len); pad_en_i = pe; crc_en_i = ce; pad_byte_i = pb;
    src_idx = 0; dones = 0; post = 0; got_n = 0; last_pos = -1; n_last = 0;
    done_busy_bad = 1'b0; got_st = '0;
    for (int cyc = 0; cyc < 6000 && post < 4; cyc++) begin
      @(negedge clk);
      start_i    = (restart != 0 && cyc == restart);
      len_i      = start_i ? 11'd5 : 11'(len);
      pad_byte_i = start_i ? 8'h00 : pb;
      m_ready_i  = gap ? (cyc % 3 != 2) : 1'b1;
      s_valid_i  = (src_idx < len) && !(gap && (cyc % 4 == 1));
      s_data_i   = src_mem[src_idx < 2048 ? src_idx : 0];
      #1;
      if (s_valid_i && s_ready_o) src_idx++;
      if (m_valid_o && m_ready_i) begin
        if (got_n < 2048) got_b[got_n] = m_data_o;
        if (m_last_o) begin last_pos = got_n; n_last++; end
        got_n++;
      end
      if (done_o) begin
        dones++;
        if (busy_o) done_busy_bad = 1'b1;
      end
      if (dones > 0) post++;
      if (dones > 0 && post == 2) got_st = status_o;
    end
    start_i = 1'b0; s_valid_i = 1'b0;

    check(got_n == n_exp, "R3", "frame byte count", got_n, n_exp);
    bad_idx = -1;
    for (int i = 0; i < n_exp && i < got_n; i++)
      if (bad_idx < 0 && got_b[i] !== exp_b[i]) bad_idx = i;
    if (bad_idx < 0) rq = "R2";
    else if (bad_idx < 7) rq = "R2";
    else if (bad_idx < 7 + eff) rq = "R3";
    else if (bad_idx < data_end) rq = "R4";
    else rq = "R5";
    check(bad_idx < 0, rq, "frame byte content",
          bad_idx < 0 ? 0 : int'(got_b[bad_idx]), bad_idx < 0 ? 0 : int'(exp_b[bad_idx]));
    check(src_idx == eff, "R6", "payload bytes consumed", src_idx, eff);
    check(got_st == exp_st, "R8", "status word", got_st, exp_st);
    check(n_last == 1 && last_pos == n_exp - 1, "R8", "last flag position", last_pos, n_exp - 1);
    check(dones == 1, "R7", "done pulses per frame", dones, 1);
    check(!done_busy_bad && !busy_o, "R8", "busy low at done", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy_o && !m_valid_o && !done_o && !s_ready_o, "R1", "outputs in reset",
          {busy_o, m_valid_o, done_o, s_ready_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !m_valid_o && !done_o && !s_ready_o, "R1", "outputs after reset",
          {busy_o, m_valid_o, done_o, s_ready_o}, 0);

    // table of frame vectors, covering R2..R9
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 2048; i++) src_mem[i] = 8'(int'(VECS[v][29:19]) + i);
      run_frame(int'(VECS[v][29:19]), VECS[v][18], VECS[v][17], VECS[v][16:9],
                VECS[v][8], int'(VECS[v][7:0]));
    end

    // R5: known check value for ASCII "123456789"
    for (int i = 0; i < 9; i++) src_mem[i] = 8'h31 + 8'(i);
    run_frame(9, 1'b0, 1'b1, 8'h88, 1'b1, 0);
    check({got_b[19], got_b[18], got_b[17], got_b[16]} == 32'hCBF43926, "R5",
          "check bytes for 123456789",
          {got_b[19], got_b[18], got_b[17], got_b[16]}, 32'hCBF43926);

    // R9: stalled output holds its byte
    for (int i = 0; i < 2048; i++) src_mem[i] = 8'(i * 3);
    @(negedge clk);
    m_ready_i = 1'b0;
    start_i = 1'b1; len_i = 11'd4; pad_en_i = 1'b0; crc_en_i = 1'b0; pad_byte_i = 8'h88;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check(m_valid_o && m_data_o == 8'h55, "R9", "stalled first byte", m_data_o, 8'h55);
    check(!s_ready_o, "R9", "no payload taken while stalled", s_ready_o, 0);
    run_frame(4, 1'b0, 1'b0, 8'h88, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule